// File: doc/BRIEF.md
# Multi-Profile RAM Burst Sequencer

This block produces the read address for a waveform playback memory. It walks that address through a fixed chain of three address segments, called profiles, and then stops. Each profile holds a first address, a last address and a step length in clock cycles. Software loads these values through a small write port. A separate update strobe samples a four-bit control code. The burst code starts the chain at profile 0.

While a burst runs, the address advances by one each time the interval timer expires. The interval comes from the step length of the active profile. When the address reaches the last address of a profile, a two-cycle end pulse is raised. The address then stays there for one more interval before the next profile's first address is loaded. After the final profile's dwell, the block drops its busy flag and freezes. The memory and the sample data path sit outside this block.

Top module: `ram_burst_seq`

## Requirements
- R1: During and right after reset, ram_addr is 0, prof_idx is 0, busy is 0 and sweep_end is 0.
- R2: ctrl_code is sampled only in a cycle with upd_strobe high. If it equals 4'b0010, then on the next cycle busy is 1, prof_idx is 0, ram_addr is profile 0's first address and sweep_end is 0.
- R3: While busy, ram_addr rises by exactly one each time the interval expires. The interval is the active profile's step length in cycles, and a step length of 0 counts as 1.
- R4: In the two cycles that follow the first cycle where ram_addr shows the active profile's last address, sweep_end is high. Two such pulses that overlap merge into one.
- R5: The address stays at the last address for one full interval of that profile. Then prof_idx goes up by one and ram_addr loads the next profile's first address. Profiles always run in the order 0, 1, 2.
- R6: After profile 2's dwell at its last address, busy falls. From then on, ram_addr and prof_idx hold until the next update strobe.
- R7: A profile whose last address is below its first address plays only its first address, for one interval.
- R8: An update strobe with the burst code during a running burst abandons that burst and restarts from profile 0. Any end pulse in progress is cleared.
- R9: An update strobe with any code other than 4'b0010 leaves the block idle. busy and sweep_end are 0 on the next cycle, and ram_addr and prof_idx hold. If a burst was running, it is aborted.
- R10: A write with cfg_we high stores cfg_data into the profile chosen by cfg_prof. The field is chosen by cfg_field: 0 stores the first address (low 10 bits), 1 stores the last address (low 10 bits), 2 stores the step length (16 bits), and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Profile register write enable |
| cfg_prof | input | 2 | Profile selected for the write |
| cfg_field | input | 2 | Field selected for the write |
| cfg_data | input | 16 | Write data |
| upd_strobe | input | 1 | Update strobe that samples ctrl_code |
| ctrl_code | input | 4 | Profile control code |
| ram_addr | output | 10 | Playback memory read address |
| prof_idx | output | 3 | Index of the active profile |
| busy | output | 1 | High while a burst runs |
| sweep_end | output | 1 | Two-cycle end-of-profile pulse |

## Verification
The bench targets four cases. The first is a zero step length, where a design that did not treat it as one would stall or wrap its timer. The second is an inverted profile: a design without the fallback would run past the first address or never match the end. The third is the one-interval dwell at every last address, where an off-by-one would jump to the next profile too early or hold the end value too long. The fourth is two end pulses landing on neighbouring cycles, which must merge into a three-cycle high. The bench also restarts and aborts bursts midway and changes ctrl_code without a strobe. A design that kept stale pulses, skipped the return to profile 0, or sampled the code outside the strobe would show a trace different from the expected one.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int ADDR_W    = 10;
    localparam int RATE_W    = 16;
    localparam int CFG_W     = 16;
    localparam int CODE_W    = 4;
    localparam int NUM_PROF  = 3;
    localparam int PIDX_W    = 3;
    localparam int PULSE_LEN = 2;
    localparam int SEL_W     = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1;

    localparam logic [CODE_W-1:0] BURST_CODE = 4'b0010;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [RATE_W-1:0] rate_t;

    typedef enum logic [1:0] {
        FLD_FIRST = 2'd0,
        FLD_LAST  = 2'd1,
        FLD_RATE  = 2'd2,
        FLD_NONE  = 2'd3
    } cfg_fld_e;

    typedef struct packed {
        addr_t first;
        addr_t last;
        rate_t rate;
    } prof_cfg_t;

    typedef struct packed {
        logic              busy;
        logic              seen;
        logic [PIDX_W-1:0] idx;
        addr_t             addr;
    } seq_state_t;

    // final address actually played by a profile (inverted range -> one sample)
    function automatic addr_t stop_addr(prof_cfg_t c);
        return (c.last < c.first) ? c.first : c.last;
    endfunction

    // interval length in cycles, zero promoted to one
    function automatic rate_t step_len(rate_t r);
        return (r == '0) ? rate_t'(1) : r;
    endfunction

endpackage

// File: rtl/rbs_prof_regs.sv
module rbs_prof_regs
    import rbs_pkg::*;
#(
    parameter int N = NUM_PROF,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SW-1:0]    sel,
    input  logic [1:0]       field,
    input  logic [CFG_W-1:0] data,
    output prof_cfg_t        cfg [N]
);

    cfg_fld_e fld;
    assign fld = cfg_fld_e'(field);

    for (genvar g = 0; g < N; g++) begin : g_prof
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[g] <= '0;
            end else if (we && sel == SW'(g)) begin
                case (fld)
                    FLD_FIRST: cfg[g].first <= data[ADDR_W-1:0];
                    FLD_LAST:  cfg[g].last  <= data[ADDR_W-1:0];
                    FLD_RATE:  cfg[g].rate  <= data[RATE_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rbs_step_timer.sv
module rbs_step_timer
    import rbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  load,
    input  rate_t load_val,
    output logic  expire
);

    rate_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= step_len(load_val);
        end else if (run && cnt > rate_t'(1)) begin
            cnt <= cnt - rate_t'(1);
        end
    end

    assign expire = run && (cnt <= rate_t'(1));

endmodule

// File: rtl/rbs_end_pulse.sv
module rbs_end_pulse #(
    parameter int LEN = 2,
    parameter int CW  = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic trig,
    output logic pulse
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (trig) begin
            cnt <= CW'(LEN);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign pulse = (cnt != '0);

endmodule

// File: rtl/rbs_seq_core.sv
module rbs_seq_core
    import rbs_pkg::*;
#(
    parameter int N  = NUM_PROF,
    parameter int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [CODE_W-1:0] code,
    input  prof_cfg_t         cfg [N],
    input  logic              expire,
    output addr_t             addr,
    output logic [PIDX_W-1:0] idx,
    output logic              busy,
    output logic              timer_load,
    output rate_t             timer_val,
    output logic              end_trig
);

    seq_state_t st, st_n;
    logic [SW-1:0] sel, nsel;
    prof_cfg_t     cur, nxt;
    logic          at_end, last;

    assign sel    = st.idx[SW-1:0];
    assign last   = (st.idx == PIDX_W'(N - 1));
    assign nsel   = last ? '0 : sel + 1'b1;
    assign cur    = cfg[sel];
    assign nxt    = cfg[nsel];
    assign at_end = (st.addr == stop_addr(cur));

    always_comb begin
        st_n       = st;
        timer_load = 1'b0;
        timer_val  = cur.rate;
        end_trig   = 1'b0;
        if (upd) begin
            st_n.seen = 1'b0;
            if (code == BURST_CODE) begin
                st_n.busy  = 1'b1;
                st_n.idx   = '0;
                st_n.addr  = cfg[0].first;
                timer_load = 1'b1;
                timer_val  = cfg[0].rate;
            end else begin
                st_n.busy = 1'b0;
            end
        end else if (st.busy) begin
            if (at_end && !st.seen) begin
                end_trig  = 1'b1;
                st_n.seen = 1'b1;
            end
            if (expire) begin
                if (!at_end) begin
                    st_n.addr  = st.addr + 1'b1;
                    timer_load = 1'b1;
                    timer_val  = cur.rate;
                end else if (last) begin
                    st_n.busy = 1'b0;
                end else begin
                    st_n.idx   = st.idx + 1'b1;
                    st_n.addr  = nxt.first;
                    st_n.seen  = 1'b0;
                    timer_load = 1'b1;
                    timer_val  = nxt.rate;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    assign addr = st.addr;
    assign idx  = st.idx;
    assign busy = st.busy;

endmodule

// File: rtl/ram_burst_seq.sv
module ram_burst_seq
    import rbs_pkg::*;
#(
    parameter int NPROF = NUM_PROF,
    parameter int PLEN  = PULSE_LEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_prof,
    input  logic [1:0]          cfg_field,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic                upd_strobe,
    input  logic [CODE_W-1:0]   ctrl_code,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [PIDX_W-1:0]   prof_idx,
    output logic                busy,
    output logic                sweep_end
);

    localparam int PSW = (NPROF > 1) ? $clog2(NPROF) : 1;

    prof_cfg_t cfg [NPROF];
    logic      expire, t_load, e_trig;
    rate_t     t_val;

    rbs_prof_regs #(.N(NPROF), .SW(PSW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_prof[PSW-1:0]),
        .field (cfg_field),
        .data  (cfg_data),
        .cfg   (cfg)
    );

    rbs_step_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .load     (t_load),
        .load_val (t_val),
        .expire   (expire)
    );

    rbs_seq_core #(.N(NPROF), .SW(PSW)) u_core (
        .clk        (clk),
        .rst        (rst),
        .upd        (upd_strobe),
        .code       (ctrl_code),
        .cfg        (cfg),
        .expire     (expire),
        .addr       (ram_addr),
        .idx        (prof_idx),
        .busy       (busy),
        .timer_load (t_load),
        .timer_val  (t_val),
        .end_trig   (e_trig)
    );

    rbs_end_pulse #(.LEN(PLEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .clear (upd_strobe),
        .trig  (e_trig),
        .pulse (sweep_end)
    );

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker
    import rbs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              upd_strobe,
    input logic [CODE_W-1:0] ctrl_code,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [PIDX_W-1:0] prof_idx,
    input logic              busy,
    input logic              sweep_end
);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe && ctrl_code == BURST_CODE) |=> (busy && prof_idx == '0 && !sweep_end)); // R2

    AST_OTHER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe && ctrl_code != BURST_CODE) |=> (!busy && !sweep_end)); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (busy && !upd_strobe) |=> (!busy || prof_idx != $past(prof_idx) ||
            ram_addr == $past(ram_addr) || ram_addr == $past(ram_addr) + 1'b1)); // R3

    AST_PULSE_TWO: assert property (@(posedge clk) disable iff (rst)
        ($rose(sweep_end) && !upd_strobe) |=> sweep_end); // R4

    AST_IDX_ORDER: assert property (@(posedge clk) disable iff (rst)
        (busy && !upd_strobe) |=> (prof_idx == $past(prof_idx) || prof_idx == $past(prof_idx) + 1'b1)); // R5

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        prof_idx < PIDX_W'(NUM_PROF)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !upd_strobe) |=> ($stable(ram_addr) && $stable(prof_idx) && !busy)); // R6

endmodule

bind ram_burst_seq rbs_checker u_rbs_chk (
    .clk        (clk),
    .rst        (rst),
    .upd_strobe (upd_strobe),
    .ctrl_code  (ctrl_code),
    .ram_addr   (ram_addr),
    .prof_idx   (prof_idx),
    .busy       (busy),
    .sweep_end  (sweep_end)
);

// File: tb/test_ram_burst_seq.sv
`timescale 1ns/1ps
module test_ram_burst_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_prof = '0;
    logic [1:0]  cfg_field = '0;
    logic [15:0] cfg_data = '0;
    logic        upd_strobe = 1'b0;
    logic [3:0]  ctrl_code = '0;
    logic [9:0]  ram_addr;
    logic [2:0]  prof_idx;
    logic        busy;
    logic        sweep_end;

    typedef struct {
        int addr;
        int idx;
        int busy;
        int pulse;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    errors = 0;
    int    b_first[3];
    int    b_last[3];
    int    b_rate[3];
    string phase = "reset";
    bit    done = 0;

    always #10 clk = ~clk;

    ram_burst_seq i_ram_burst_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_prof   (cfg_prof),
        .cfg_field  (cfg_field),
        .cfg_data   (cfg_data),
        .upd_strobe (upd_strobe),
        .ctrl_code  (ctrl_code),
        .ram_addr   (ram_addr),
        .prof_idx   (prof_idx),
        .busy       (busy),
        .sweep_end  (sweep_end)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    // monitor: compares one expected item per cycle, away from the edge
    always @(posedge clk) begin : mon
        exp_t e;
        #5;
        if (q.size() != 0) begin
            e = q.pop_front();
            chk("R3 ram_addr", int'(ram_addr), e.addr);
            chk("R5 prof_idx", int'(prof_idx), e.idx);
            chk("R6 busy", int'(busy), e.busy);
            chk("R4 sweep_end", int'(sweep_end), e.pulse);
        end
    end

    // R10: one register write
    task automatic cfg_wr(input int p, input int f, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_prof = 2'(p); cfg_field = 2'(f); cfg_data = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_prof(input int p, input int f, input int l, input int r);
        b_first[p] = f; b_last[p] = l; b_rate[p] = r;
        cfg_wr(p, 0, f);
        cfg_wr(p, 1, l);
        cfg_wr(p, 2, r);
        cfg_wr(p, 3, 16'hffff); // ignored field select
    endtask

    // expected trace built from the requirements
    task automatic push_burst(input int tail);
        exp_t tr[$];
        int   ends[$];
        int   e_a = 0;
        for (int p = 0; p < 3; p++) begin
            int s = b_first[p];
            int e = (b_last[p] < s) ? s : b_last[p]; // R7
            int r = (b_rate[p] == 0) ? 1 : b_rate[p];
            for (int a = s; a <= e; a++) begin
                if (a == e) ends.push_back(tr.size());
                for (int k = 0; k < r; k++) tr.push_back('{a, p, 1, 0});
            end
            e_a = e;
        end
        for (int k = 0; k < tail; k++) tr.push_back('{e_a, 2, 0, 0});
        foreach (ends[i])
            for (int d = 1; d <= 2; d++)
                if (ends[i] + d < tr.size()) tr[ends[i] + d].pulse = 1;
        foreach (tr[i]) q.push_back(tr[i]);
    endtask

    task automatic start_burst(input string ph);
        @(negedge clk);
        q.delete();
        phase = ph;
        push_burst(6);
        upd_strobe = 1'b1; ctrl_code = 4'b0010;
        @(negedge clk);
        upd_strobe = 1'b0;
    endtask

    task automatic strobe_other(input string ph, input logic [3:0] code, input int n);
        @(negedge clk);
        q.delete();
        phase = ph;
        for (int k = 0; k < n; k++) q.push_back('{int'(ram_addr), int'(prof_idx), 0, 0});
        upd_strobe = 1'b1; ctrl_code = code;
        @(negedge clk);
        upd_strobe = 1'b0;
    endtask

    task automatic wait_drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        phase = "R1 reset";
        chk("R1 ram_addr", int'(ram_addr), 0);
        chk("R1 busy", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ram_addr", int'(ram_addr), 0);
        chk("R1 prof_idx", int'(prof_idx), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 sweep_end", int'(sweep_end), 0);

        // R10 writes; R7 inverted profile 2; R3 zero step length in profile 1
        set_prof(0, 5, 8, 3);
        set_prof(1, 20, 21, 0);
        set_prof(2, 40, 38, 2);
        start_burst("R2 R5 R7 burst A");
        wait_drain();

        // R9 non-burst code while idle: nothing moves
        strobe_other("R9 idle code", 4'b0001, 8);
        wait_drain();

        set_prof(0, 100, 104, 2);
        set_prof(1, 200, 200, 1);
        set_prof(2, 300, 302, 1);
        start_burst("R2 burst B");
        repeat (7) @(negedge clk);
        // R8 restart mid-burst from profile 0
        start_burst("R8 restart");
        repeat (3) @(negedge clk);
        ctrl_code = 4'b0001; // R2 code ignored without a strobe
        wait_drain();

        start_burst("R2 burst C");
        repeat (4) @(negedge clk);
        // R9 abort with a foreign code: hold address and index
        strobe_other("R9 abort", 4'b0111, 8);
        wait_drain();

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog [%s] actual=hung expected=done", phase);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule